// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block plays the read side of a clocked burst memory. A host holds chip enable high, pulses `start` with a start address, and the block fetches words from a small internal word array. The access latency and the burst mode come from static configuration inputs. After the configured number of clocks the block presents one word per clock on `dout`. While an access is open but no valid word is on the bus, `wait_o` is high.

Three fixed-length modes deliver 4, 8 or 16 words. Each wraps inside the aligned block that holds the start address. A continuous mode walks the address up linearly, with no wrap, until the last word of the array. The first time a continuous burst steps into a new internal row, the block inserts a short stall and flags it on `wait_o`. This happens at most once per burst. Dropping chip enable abandons any access at once.

Top module: `burst_read_seq`

## Requirements
- R1: Mode code 3'b001 on `len_code` gives a 4-word burst. The address wraps inside the aligned 4-word block that holds the start address, and the burst ends after exactly 4 words.
- R2: Mode code 3'b010 gives an 8-word burst. It wraps inside the aligned 8-word block and ends after 8 words.
- R3: Mode code 3'b011 gives a 16-word burst. It wraps inside the aligned 16-word block and ends after 16 words.
- R4: The first word appears on `dout` exactly `lat_cfg` clocks after the clock edge that accepts `start`, with `wait_o` and `burst_busy` high for all of those clocks. A `lat_cfg` of 0 acts as 1.
- R5: In continuous mode the address rises by one per word and never wraps. The burst ends after the word at the highest array address, and then `burst_busy` falls.
- R6: In continuous mode, the first step onto a row-start address (in-row offset zero) that differs from the start address inserts `lat_cfg`-1 stall clocks. `wait_o` is high and `dout` is zero during the stall. Later row crossings in the same burst add no stall.
- R7: A continuous burst that never steps onto a row start has no stall. With `lat_cfg` at 1 or 0, a crossing adds no stall either.
- R8: Every `len_code` value other than 3'b001, 3'b010 and 3'b011 selects continuous mode.
- R9: While `chip_en` is low, in the same cycle, `wait_o`, `burst_busy` and `dout` are all zero. The open access is dropped.
- R10: A `start` pulse while a burst is in progress has no effect on the words delivered.
- R11: The word at address a holds (a*40503 XOR 23130) mod 2^16. `dout` is zero whenever no valid word is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chip_en | input | 1 | Chip enable; low aborts and idles the block |
| start | input | 1 | Opens an access when the block is idle |
| start_addr | input | ADDR_W | First word address of the access |
| lat_cfg | input | LAT_W | Initial latency in clocks |
| len_code | input | 3 | Burst mode code |
| dout | output | DATA_W | Delivered word, zero when not valid |
| wait_o | output | 1 | High while an access is open and no valid word is out |
| burst_busy | output | 1 | High while an access is open |

## Verification
The bench builds the block with its defaults: a 64-word array split into four 16-word rows. With that size, a continuous burst can cross several rows and reach the top of the array within a few dozen clocks. This makes it possible to check that only the first crossing stalls and that the burst stops at the last address. Start addresses in the middle of aligned blocks exercise the wrap in every fixed mode. Latencies of 0, 1 and larger values cover both the no-stall case and the normal stall length.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LAT   = 2'd1,
        ST_DATA  = 2'd2,
        ST_STALL = 2'd3
    } seq_state_e;

    localparam logic [2:0] MODE_W4  = 3'b001;
    localparam logic [2:0] MODE_W8  = 3'b010;
    localparam logic [2:0] MODE_W16 = 3'b011;
endpackage

// File: rtl/burst_len_dec.sv
module burst_len_dec
    import burst_rd_pkg::*;
(
    input  logic [2:0] len_code,
    output logic       cont,
    output logic [2:0] size_log
);
    always_comb begin
        cont     = 1'b0;
        size_log = 3'd2;
        case (len_code)
            MODE_W4:  size_log = 3'd2;
            MODE_W8:  size_log = 3'd3;
            MODE_W16: size_log = 3'd4;
            default:  cont     = 1'b1;
        endcase
    end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
    parameter int ADDR_W    = 6,
    parameter int ROW_WORDS = 16
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              cont,
    input  logic [2:0]        size_log,
    output logic [ADDR_W-1:0] nxt,
    output logic              row_start,
    output logic              at_top
);
    localparam int ROW_LOG = $clog2(ROW_WORDS);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc  = cur + ADDR_W'(1);
        mask = (ADDR_W'(1) << size_log) - ADDR_W'(1);
        if (cont) begin
            nxt = inc;
        end else begin
            nxt = (cur & ~mask) | (inc & mask);
        end
        row_start = (nxt[ROW_LOG-1:0] == '0);
        at_top    = (cur == {ADDR_W{1'b1}});
    end
endmodule

// File: rtl/burst_word_array.sv
module burst_word_array #(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 16,
    parameter int FILL_MUL = 40503,
    parameter int FILL_XOR = 23130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    function automatic logic [DATA_W-1:0] fill_word(input int idx);
        return DATA_W'((idx * FILL_MUL) ^ FILL_XOR);
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[g] <= fill_word(g);
            end else begin
                words_q[g] <= words_q[g];
            end
        end
    end

    assign rdata = words_q[raddr];
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
    import burst_rd_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DATA_W    = 16,
    parameter int LAT_W     = 4,
    parameter int ROW_WORDS = 16,
    parameter int FILL_MUL  = 40503,
    parameter int FILL_XOR  = 23130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LAT_W-1:0]  lat_cfg,
    input  logic [2:0]        len_code,
    output logic [DATA_W-1:0] dout,
    output logic              wait_o,
    output logic              burst_busy
);
    localparam int WCNT_W = 5;

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] first;
        logic [LAT_W-1:0]  cnt;
        logic [LAT_W-1:0]  lat;
        logic [WCNT_W-1:0] words;
        logic              cont;
        logic [2:0]        size_log;
        logic              stalled;
    } seq_t;

    seq_t st_d, st_q;

    logic              dec_cont;
    logic [2:0]        dec_size;
    logic [ADDR_W-1:0] nxt_addr;
    logic              nxt_row_start;
    logic              cur_at_top;
    logic [DATA_W-1:0] arr_word;
    logic [LAT_W-1:0]  lat_eff;
    logic [WCNT_W-1:0] words_n;
    logic              fix_done;

    burst_len_dec i_dec (
        .len_code (len_code),
        .cont     (dec_cont),
        .size_log (dec_size)
    );

    burst_addr_step #(
        .ADDR_W    (ADDR_W),
        .ROW_WORDS (ROW_WORDS)
    ) i_step (
        .cur       (st_q.addr),
        .cont      (st_q.cont),
        .size_log  (st_q.size_log),
        .nxt       (nxt_addr),
        .row_start (nxt_row_start),
        .at_top    (cur_at_top)
    );

    burst_word_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .FILL_MUL (FILL_MUL),
        .FILL_XOR (FILL_XOR)
    ) i_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (st_q.addr),
        .rdata (arr_word)
    );

    always_comb begin
        st_d     = st_q;
        lat_eff  = (lat_cfg == '0) ? LAT_W'(1) : lat_cfg;
        words_n  = st_q.words + WCNT_W'(1);
        fix_done = !st_q.cont && (words_n == (WCNT_W'(1) << st_q.size_log));
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    st_d.state    = ST_LAT;
                    st_d.addr     = start_addr;
                    st_d.first    = start_addr;
                    st_d.cnt      = lat_eff - LAT_W'(1);
                    st_d.lat      = lat_eff;
                    st_d.words    = '0;
                    st_d.cont     = dec_cont;
                    st_d.size_log = dec_size;
                    st_d.stalled  = 1'b0;
                end
            end
            ST_LAT, ST_STALL: begin
                if (st_q.cnt == '0) begin
                    st_d.state = ST_DATA;
                end else begin
                    st_d.cnt = st_q.cnt - LAT_W'(1);
                end
            end
            ST_DATA: begin
                if (fix_done || (st_q.cont && cur_at_top)) begin
                    st_d = '0;
                end else begin
                    st_d.addr  = nxt_addr;
                    st_d.words = words_n;
                    if (st_q.cont && !st_q.stalled && nxt_row_start &&
                        (nxt_addr != st_q.first) && (st_q.lat > LAT_W'(1))) begin
                        st_d.state   = ST_STALL;
                        st_d.cnt     = st_q.lat - LAT_W'(2);
                        st_d.stalled = 1'b1;
                    end
                end
            end
            default: st_d = '0;
        endcase
        if (!chip_en) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign burst_busy = chip_en && (st_q.state != ST_IDLE);
    assign wait_o     = chip_en && ((st_q.state == ST_LAT) || (st_q.state == ST_STALL));
    assign dout       = (chip_en && (st_q.state == ST_DATA)) ? arr_word : '0;
endmodule

// File: rtl/burst_read_seq_chk.sv
module burst_read_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              start,
    input logic              wait_o,
    input logic              burst_busy,
    input logic [DATA_W-1:0] dout
);
    logic       data_seen_q;
    logic       wait_q;
    logic [1:0] stalls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_seen_q <= 1'b0;
            wait_q      <= 1'b0;
            stalls_q    <= '0;
        end else begin
            wait_q <= wait_o;
            if (!burst_busy) begin
                data_seen_q <= 1'b0;
                stalls_q    <= '0;
            end else begin
                if (!wait_o) data_seen_q <= 1'b1;
                if (wait_o && !wait_q && data_seen_q && stalls_q != 2'd3)
                    stalls_q <= stalls_q + 2'd1;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |-> (!wait_o && !burst_busy && dout == '0)); // R9

    AST_START_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && start && !burst_busy) |=> (wait_o || !chip_en)); // R4

    AST_WAIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (burst_busy && dout == '0)); // R11

    AST_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        stalls_q <= 2'd1); // R6
endmodule

bind burst_read_seq burst_read_seq_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .start      (start),
    .wait_o     (wait_o),
    .burst_busy (burst_busy),
    .dout       (dout)
);

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int LAT_W  = 4;
    localparam int ROW    = 16;
    localparam int TOP    = (1 << ADDR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chip_en = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LAT_W-1:0]  lat_cfg = '0;
    logic [2:0]        len_code = '0;
    logic [DATA_W-1:0] dout;
    logic              wait_o;
    logic              burst_busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    burst_read_seq i_burst_read_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .start      (start),
        .start_addr (start_addr),
        .lat_cfg    (lat_cfg),
        .len_code   (len_code),
        .dout       (dout),
        .wait_o     (wait_o),
        .burst_busy (burst_busy)
    );

    function automatic logic [DATA_W-1:0] ref_word(input int a);
        return DATA_W'((a * 40503) ^ 23130);
    endfunction

    task automatic check(input string req, input logic [17:0] exp);
        logic [17:0] act;
        act = {wait_o, burst_busy, dout};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: wait/busy/dout got %b/%b/%h expected %b/%b/%h",
                     req, act[17], act[16], act[15:0], exp[17], exp[16], exp[15:0]);
        end
    endtask

    // drop_at: cycle index where chip_en falls; ign_at: cycle index with a stray start
    task automatic run_burst(input string req, input int addr, input int lat,
                             input logic [2:0] code, input int drop_at, input int ign_at);
        logic [17:0] q[$];
        int lat_e, n, base, a, nx;
        bit cont, stalled;
        lat_e = (lat == 0) ? 1 : lat;
        for (int i = 0; i < lat_e; i++) q.push_back({1'b1, 1'b1, 16'h0});
        cont = !(code == 3'b001 || code == 3'b010 || code == 3'b011);
        if (!cont) begin
            n = (code == 3'b001) ? 4 : (code == 3'b010) ? 8 : 16;
            base = addr - (addr % n);
            for (int k = 0; k < n; k++) begin
                a = base + ((addr - base + k) % n);
                q.push_back({1'b0, 1'b1, ref_word(a)});
            end
        end else begin
            a = addr;
            stalled = 1'b0;
            forever begin
                q.push_back({1'b0, 1'b1, ref_word(a)});
                if (a == TOP) break;
                nx = a + 1;
                if (!stalled && (nx % ROW) == 0 && nx != addr && lat_e > 1) begin
                    for (int s = 0; s < lat_e - 1; s++) q.push_back({1'b1, 1'b1, 16'h0});
                    stalled = 1'b1;
                end
                a = nx;
            end
        end
        q.push_back({1'b0, 1'b0, 16'h0});
        if (drop_at >= 0) begin
            while (q.size() > drop_at + 2) void'(q.pop_back());
            for (int i = drop_at; i < q.size(); i++) q[i] = 18'h0;
        end
        start_addr = ADDR_W'(addr);
        lat_cfg    = LAT_W'(lat);
        len_code   = code;
        start      = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        for (int i = 0; i < q.size(); i++) begin
            if (i == drop_at) chip_en = 1'b0;
            if (i == ign_at) begin
                start = 1'b1;
                start_addr = ADDR_W'(addr + 21);
            end
            #8;
            check(req, q[i]);
            @(posedge clk); #2;
            start = 1'b0;
        end
        chip_en = 1'b1;
        @(posedge clk); #2;
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n   = 1'b1;
        chip_en = 1'b1;
        #8;
        check("R9 reset idle", 18'h0);
        @(posedge clk); #2;
        run_burst("R1 4-word wrap", 6, 3, 3'b001, -1, -1);
        run_burst("R2 8-word wrap", 13, 2, 3'b010, -1, -1);
        run_burst("R3 16-word wrap", 37, 4, 3'b011, -1, -1);
        run_burst("R4 zero latency acts as one", 9, 0, 3'b001, -1, -1);
        run_burst("R5 continuous to top", 58, 2, 3'b111, -1, -1);
        run_burst("R6 single stall on first crossing", 12, 5, 3'b111, -1, -1);
        run_burst("R7 no crossing inside row", 48, 3, 3'b111, -1, -1);
        run_burst("R7 latency one crossing", 30, 1, 3'b111, -1, -1);
        run_burst("R8 unused code continuous", 60, 2, 3'b101, -1, -1);
        run_burst("R8 code zero continuous", 44, 3, 3'b000, -1, -1);
        run_burst("R9 chip enable drop", 2, 3, 3'b011, 6, -1);
        run_burst("R10 start ignored while busy", 20, 2, 3'b010, -1, 4);
        run_burst("R11 array contents", 0, 2, 3'b011, -1, -1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule